// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises bytes onto a single asynchronous output line. Software-side logic writes a data word into a one-entry holding register. Whenever the frame engine is free, it copies that word into its own shift register. Because of this split, one frame can be sent while the next waits in the holding register. The holding register also keeps a separate multiprocessor-bit value, which is written at the same time as the data.

Two status flags report progress, and each can raise its own interrupt request:
- The **empty** flag says the holding register may be written again.
- The **end** flag says the line has gone idle because no further data was waiting.

The engine looks at the holding register when the first stop bit starts. If data is waiting, the next start bit follows the last stop bit with no idle gap.

The frame format is chosen per frame:
- 7 or 8 data bits.
- An optional extra bit after the data: even parity, odd parity or a multiprocessor bit.
- One or two stop bits.

Bit timing comes from an external baud-enable pulse. Each bit lasts `TICKS_PER_BIT` of these pulses.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `empty_flag` and `end_flag` are 1, and each interrupt output follows its flag while its enable is set.
- R2: A cycle with `wr_en` high stores `wr_data` and `wr_mpb`, and clears both `empty_flag` and `end_flag` from the next cycle on.
- R3: When the engine is idle and `empty_flag` is 0, the word moves to the shift register one cycle later, `empty_flag` returns to 1 in that same cycle, and `txd` drops to 0 for the start bit.
- R4: A frame is one 0 start bit, then the data bits least significant bit first, then the optional extra bit, then the stop bits as 1. Each bit lasts exactly `TICKS_PER_BIT` baud-enable pulses.
- R5: When `cfg_len7` is 1, only data bits 0 to 6 are sent and bit 7 of the word has no effect on the line.
- R6: `cfg_extra` selects the bit after the data: 00 means no extra bit; 01 means even parity (the bit equals the XOR of the active data bits); 10 means odd parity (the inverse of that XOR); 11 means the stored `wr_mpb` value.
- R7: `cfg_stop2` set to 1 sends two stop bits; set to 0 it sends one.
- R8: If `empty_flag` is 0 when the first stop bit begins, the waiting word is taken at that moment, `empty_flag` returns to 1, and the next start bit begins directly after the last stop bit.
- R9: If `empty_flag` is 1 when the first stop bit begins, `end_flag` is set in that cycle, the stop bit(s) complete, and `txd` then stays at 1 until a later start bit.
- R10: `irq_empty` is `empty_flag` AND `txie`; `irq_end` is `end_flag` AND `teie`.
- R11: Bit timing advances only on cycles with `baud_tick` high; with no pulses, `txd` holds its current bit.
- R12: The format inputs are captured when a word is taken; a format change during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Baud-rate enable pulse |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to send |
| wr_mpb | input | 1 | Multiprocessor bit value stored with the word |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_extra | input | 2 | Extra bit selection (00 none, 01 even, 10 odd, 11 multiprocessor) |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| txie | input | 1 | Enable for the empty interrupt |
| teie | input | 1 | Enable for the end interrupt |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Holding register may be written |
| end_flag | output | 1 | Transmission has ended, line idle |
| irq_empty | output | 1 | Empty interrupt request |
| irq_end | output | 1 | End interrupt request |

## Verification
The bench builds the block with `DATA_W` = 8 and `TICKS_PER_BIT` = 4, and drives a baud pulse on every cycle, so one bit lasts four clocks. This keeps all sixteen format combinations short enough to send in one run. It also makes gapless back-to-back frames and the exact cycle at which `end_flag` rises measurable as fixed clock distances. Holding the baud pulse low partway through a frame shows that the line timing comes only from the pulse, not from the clock.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  // Selection of the optional bit that follows the data bits
  typedef enum logic [1:0] {
    EXTRA_NONE = 2'b00,
    EXTRA_EVEN = 2'b01,
    EXTRA_ODD  = 2'b10,
    EXTRA_MPB  = 2'b11
  } extra_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP
  } txst_e;

  // Frame format captured per frame
  typedef struct packed {
    logic   len7;
    extra_e extra;
    logic   stop2;
  } fmt_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mpb,
  input  logic              take,
  input  logic              set_end,
  input  logic              txie,
  input  logic              teie,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_mpb,
  output logic              empty,
  output logic              tend,
  output logic              irq_empty,
  output logic              irq_end
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              mpb_q, mpb_d;
  logic              empty_q, empty_d;
  logic              tend_q, tend_d;

  // Next-state: a write always wins over a same-cycle take or end event
  always_comb begin
    data_d  = data_q;
    mpb_d   = mpb_q;
    empty_d = empty_q;
    tend_d  = tend_q;
    if (take)    empty_d = 1'b1;
    if (set_end) tend_d  = 1'b1;
    if (wr_en) begin
      data_d  = wr_data;
      mpb_d   = wr_mpb;
      empty_d = 1'b0;
      tend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      mpb_q   <= 1'b0;
      empty_q <= 1'b1;
      tend_q  <= 1'b1;
    end else begin
      data_q  <= data_d;
      mpb_q   <= mpb_d;
      empty_q <= empty_d;
      tend_q  <= tend_d;
    end
  end

  assign hold_data = data_q;
  assign hold_mpb  = mpb_q;
  assign empty     = empty_q;
  assign tend      = tend_q;
  assign irq_empty = empty_q & txie;
  assign irq_end   = tend_q & teie;

  AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !empty_q); // R2
  AST_WR_CLEARS_END: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> !tend_q); // R2
  AST_TAKE_REFILLS: assert property (@(posedge clk) disable iff (!rst_n) (take && !wr_en) |=> empty_q); // R3
  AST_END_WITH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) $rose(tend_q) |-> empty_q); // R9

endmodule

// File: rtl/sertx_bittimer.sv
module sertx_bittimer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_tick,
  input  logic run,
  input  logic restart,
  output logic bit_done
);

  localparam int            CW   = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv;

  assign adv      = run & baud_tick;
  assign bit_done = adv & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST); // R4
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!baud_tick && !restart) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_done,
  input  logic              hold_empty,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_mpb,
  input  fmt_t              cfg,
  output logic              take,
  output logic              set_end,
  output logic              restart,
  output logic              run,
  output logic              txd
);

  localparam int                IW         = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0]     IDX_FULL   = IW'(DATA_W - 1);
  localparam logic [IW-1:0]     IDX_SHORT  = IW'(DATA_W - 2);
  localparam logic [DATA_W-1:0] MASK_FULL  = '1;
  localparam logic [DATA_W-1:0] MASK_SHORT = MASK_FULL >> 1;

  txst_e             state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] pdat_q, pdat_d;
  fmt_t              fmt_q, fmt_d;
  fmt_t              pfmt_q, pfmt_d;
  logic              xbit_q, xbit_d;
  logic              pxbit_q, pxbit_d;
  logic              pend_q, pend_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              stop_q, stop_d;
  logic              enter_stop;
  logic              cap_par;
  logic              cap_x;
  logic [IW-1:0]     last_idx;

  // Extra bit computed from the holding register and the live format
  assign cap_par = ^(hold_data & (cfg.len7 ? MASK_SHORT : MASK_FULL));

  always_comb begin
    unique case (cfg.extra)
      EXTRA_EVEN: cap_x = cap_par;
      EXTRA_ODD:  cap_x = ~cap_par;
      EXTRA_MPB:  cap_x = hold_mpb;
      default:    cap_x = 1'b1;
    endcase
  end

  assign last_idx = fmt_q.len7 ? IDX_SHORT : IDX_FULL;

  always_comb begin
    state_d    = state_q;
    sh_d       = sh_q;
    fmt_d      = fmt_q;
    xbit_d     = xbit_q;
    pdat_d     = pdat_q;
    pfmt_d     = pfmt_q;
    pxbit_d    = pxbit_q;
    pend_d     = pend_q;
    idx_d      = idx_q;
    stop_d     = stop_q;
    take       = 1'b0;
    set_end    = 1'b0;
    restart    = 1'b0;
    enter_stop = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!hold_empty) begin
          take    = 1'b1;
          restart = 1'b1;
          sh_d    = hold_data;
          fmt_d   = cfg;
          xbit_d  = cap_x;
          state_d = ST_START;
        end
      end
      ST_START: begin
        if (bit_done) begin
          idx_d   = '0;
          state_d = ST_DATA;
        end
      end
      ST_DATA: begin
        if (bit_done) begin
          sh_d = sh_q >> 1;
          if (idx_q == last_idx) begin
            if (fmt_q.extra != EXTRA_NONE) state_d = ST_EXTRA;
            else                           enter_stop = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_EXTRA: begin
        if (bit_done) enter_stop = 1'b1;
      end
      ST_STOP: begin
        if (bit_done) begin
          if (fmt_q.stop2 && !stop_q) begin
            stop_d = 1'b1;
          end else if (pend_q) begin
            state_d = ST_START;
            sh_d    = pdat_q;
            fmt_d   = pfmt_q;
            xbit_d  = pxbit_q;
            pend_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    // The holding register is examined as the first stop bit begins
    if (enter_stop) begin
      state_d = ST_STOP;
      stop_d  = 1'b0;
      if (!hold_empty) begin
        take    = 1'b1;
        pend_d  = 1'b1;
        pdat_d  = hold_data;
        pfmt_d  = cfg;
        pxbit_d = cap_x;
      end else begin
        set_end = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      fmt_q   <= '0;
      xbit_q  <= 1'b1;
      pdat_q  <= '0;
      pfmt_q  <= '0;
      pxbit_q <= 1'b1;
      pend_q  <= 1'b0;
      idx_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      fmt_q   <= fmt_d;
      xbit_q  <= xbit_d;
      pdat_q  <= pdat_d;
      pfmt_q  <= pfmt_d;
      pxbit_q <= pxbit_d;
      pend_q  <= pend_d;
      idx_q   <= idx_d;
      stop_q  <= stop_d;
    end
  end

  assign run = (state_q != ST_IDLE);

  always_comb begin
    unique case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh_q[0];
      ST_EXTRA: txd = xbit_q;
      default:  txd = 1'b1;
    endcase
  end

  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE) |-> !pend_q); // R8
  AST_STOP_ENTRY_DECIDED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && $past(state_q) != ST_STOP) |-> (pend_q || $past(set_end))); // R9

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_mpb,
  input  logic              cfg_len7,
  input  logic [1:0]        cfg_extra,
  input  logic              cfg_stop2,
  input  logic              txie,
  input  logic              teie,
  output logic              txd,
  output logic              empty_flag,
  output logic              end_flag,
  output logic              irq_empty,
  output logic              irq_end
);

  logic [DATA_W-1:0] hold_data;
  logic              hold_mpb;
  logic              take;
  logic              set_end;
  logic              restart;
  logic              run;
  logic              bit_done;
  fmt_t              cfg;

  assign cfg.len7  = cfg_len7;
  assign cfg.extra = extra_e'(cfg_extra);
  assign cfg.stop2 = cfg_stop2;

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_mpb    (wr_mpb),
    .take      (take),
    .set_end   (set_end),
    .txie      (txie),
    .teie      (teie),
    .hold_data (hold_data),
    .hold_mpb  (hold_mpb),
    .empty     (empty_flag),
    .tend      (end_flag),
    .irq_empty (irq_empty),
    .irq_end   (irq_end)
  );

  sertx_bittimer #(.TICKS(TICKS_PER_BIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .run       (run),
    .restart   (restart),
    .bit_done  (bit_done)
  );

  sertx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_done   (bit_done),
    .hold_empty (empty_flag),
    .hold_data  (hold_data),
    .hold_mpb   (hold_mpb),
    .cfg        (cfg),
    .take       (take),
    .set_end    (set_end),
    .restart    (restart),
    .run        (run),
    .txd        (txd)
  );

endmodule

// File: tb/sertx_dbuf_test.sv
`timescale 1ns/1ps
module sertx_dbuf_test;

  localparam int TPB     = 4;
  localparam int BIT_CYC = TPB;

  // {data[7:0], mpb, len7, extra[1:0], stop2}
  localparam logic [12:0] VEC [16] = '{
    {8'hA5, 1'b0, 1'b0, 2'd0, 1'b0},
    {8'h3C, 1'b0, 1'b0, 2'd1, 1'b0},
    {8'h3C, 1'b0, 1'b0, 2'd2, 1'b0},
    {8'h81, 1'b1, 1'b0, 2'd3, 1'b0},
    {8'h81, 1'b0, 1'b0, 2'd3, 1'b1},
    {8'hFF, 1'b0, 1'b0, 2'd1, 1'b1},
    {8'h00, 1'b0, 1'b0, 2'd2, 1'b1},
    {8'h5A, 1'b0, 1'b0, 2'd0, 1'b1},
    {8'hC3, 1'b0, 1'b1, 2'd0, 1'b0},
    {8'h96, 1'b0, 1'b1, 2'd1, 1'b0},
    {8'h96, 1'b0, 1'b1, 2'd2, 1'b0},
    {8'h7F, 1'b1, 1'b1, 2'd3, 1'b0},
    {8'h80, 1'b0, 1'b1, 2'd3, 1'b1},
    {8'hE1, 1'b0, 1'b1, 2'd1, 1'b1},
    {8'h0E, 1'b0, 1'b1, 2'd2, 1'b1},
    {8'hFF, 1'b0, 1'b1, 2'd0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       wr_mpb;
  logic       cfg_len7;
  logic [1:0] cfg_extra;
  logic       cfg_stop2;
  logic       txie;
  logic       teie;
  logic       txd;
  logic       empty_flag;
  logic       end_flag;
  logic       irq_empty;
  logic       irq_end;

  int         checks = 0;
  int         fails  = 0;
  int         cyc    = 0;
  logic       mon_en;
  int         mon_frames;
  int         mon_starts;
  logic [11:0] mon_bits;
  int         mon_start [64];
  logic       mon_end_at [64];

  sertx_dbuf #(.DATA_W(8), .TICKS_PER_BIT(TPB)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_mpb     (wr_mpb),
    .cfg_len7   (cfg_len7),
    .cfg_extra  (cfg_extra),
    .cfg_stop2  (cfg_stop2),
    .txie       (txie),
    .teie       (teie),
    .txd        (txd),
    .empty_flag (empty_flag),
    .end_flag   (end_flag),
    .irq_empty  (irq_empty),
    .irq_end    (irq_end)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_len(logic l7, logic [1:0] x, logic s2);
    return 1 + (l7 ? 7 : 8) + ((x != 2'd0) ? 1 : 0) + (s2 ? 2 : 1);
  endfunction

  function automatic logic [11:0] ref_frame(logic [7:0] d, logic m, logic l7, logic [1:0] x);
    logic [11:0] f;
    int          k;
    logic        p;
    f    = '1;
    f[0] = 1'b0;
    k    = 1;
    for (int i = 0; i < (l7 ? 7 : 8); i++) begin
      f[k] = d[i];
      k++;
    end
    p = l7 ? ^d[6:0] : ^d;
    case (x)
      2'd1:    f[k] = p;
      2'd2:    f[k] = ~p;
      2'd3:    f[k] = m;
      default: f[k] = 1'b1;
    endcase
    return f;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic m);
    @(negedge clk);
    wr_data = d;
    wr_mpb  = m;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_frames(int target);
    int n = 0;
    while (mon_frames < target && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_starts(int target);
    int n = 0;
    while (mon_starts < target && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!end_flag && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (3 * BIT_CYC) @(negedge clk);
  endtask

  // Line decoder: samples each bit in its middle
  initial begin
    mon_frames = 0;
    mon_starts = 0;
    mon_bits   = '1;
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && txd == 1'b0) begin
        int          nb;
        logic [11:0] bits;
        nb = ref_len(cfg_len7, cfg_extra, cfg_stop2);
        if (mon_starts < 64) begin
          mon_start[mon_starts]  = cyc;
          mon_end_at[mon_starts] = end_flag;
        end
        mon_starts++;
        bits = '1;
        repeat (BIT_CYC / 2) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < nb; i++) begin
          repeat (BIT_CYC) @(negedge clk);
          bits[i] = txd;
        end
        mon_bits = bits;
        mon_frames++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    int c_end;
    int lows;
    int f0;
    int s0;
    rst_n     = 1'b0;
    baud_tick = 1'b1;
    wr_en     = 1'b0;
    wr_data   = '0;
    wr_mpb    = 1'b0;
    cfg_len7  = 1'b0;
    cfg_extra = 2'd0;
    cfg_stop2 = 1'b0;
    txie      = 1'b1;
    teie      = 1'b1;
    mon_en    = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 txd", txd, 1);
    check("R1 empty_flag", empty_flag, 1);
    check("R1 end_flag", end_flag, 1);
    check("R1 irq_empty", irq_empty, 1);
    check("R1 irq_end", irq_end, 1);

    // R10 enables gate the requests
    txie = 1'b0;
    teie = 1'b0;
    #1;
    check("R10 irq_empty masked", irq_empty, 0);
    check("R10 irq_end masked", irq_end, 0);
    txie = 1'b1;
    teie = 1'b1;

    // R2, R3, R10: write then transfer
    f0 = mon_frames;
    put(8'hA5, 1'b0);
    check("R2 empty cleared", empty_flag, 0);
    check("R2 end cleared", end_flag, 0);
    check("R10 irq_empty low", irq_empty, 0);
    check("R10 irq_end low", irq_end, 0);
    check("R3 line high before transfer", txd, 1);
    @(negedge clk);
    check("R3 empty refilled", empty_flag, 1);
    check("R3 start bit", txd, 0);
    check("R10 irq_empty raised", irq_empty, 1);
    wait_frames(f0 + 1);
    check("R4 first frame", mon_bits, ref_frame(8'hA5, 1'b0, 1'b0, 2'd0));
    wait_idle();
    check("R10 irq_end raised", irq_end, 1);

    // R4 R5 R6 R7: every format combination
    for (int v = 0; v < 16; v++) begin
      logic [12:0] e;
      int          fv;
      e = VEC[v];
      wait_idle();
      @(negedge clk);
      cfg_len7  = e[3];
      cfg_extra = e[2:1];
      cfg_stop2 = e[0];
      fv = mon_frames;
      put(e[12:5], e[4]);
      wait_frames(fv + 1);
      check($sformatf("R4 R5 R6 R7 vector %0d", v), mon_bits,
            ref_frame(e[12:5], e[4], e[3], e[2:1]));
    end

    // R8 R9: back-to-back frames, end flag timing
    wait_idle();
    @(negedge clk);
    cfg_len7  = 1'b0;
    cfg_extra = 2'd0;
    cfg_stop2 = 1'b0;
    k  = mon_starts;
    f0 = mon_frames;
    put(8'h12, 1'b0);
    @(negedge clk);
    put(8'h34, 1'b0);
    wait_starts(k + 2);
    check("R8 no gap between frames", mon_start[k + 1] - mon_start[k], 10 * BIT_CYC);
    check("R9 end flag low while next frame waited", mon_end_at[k + 1], 0);
    c_end = 0;
    for (int n = 0; n < 200 && !end_flag; n++) @(negedge clk);
    c_end = cyc;
    check("R9 end flag at stop start", c_end - mon_start[k + 1], 9 * BIT_CYC);
    wait_frames(f0 + 2);
    check("R8 second frame", mon_bits, ref_frame(8'h34, 1'b0, 1'b0, 2'd0));
    lows = 0;
    repeat (5 * BIT_CYC) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    check("R9 line stays high", lows, 0);

    // R12: format change during a frame
    wait_idle();
    s0 = mon_starts;
    f0 = mon_frames;
    put(8'h6B, 1'b0);
    wait_starts(s0 + 1);
    cfg_len7  = 1'b1;
    cfg_extra = 2'd1;
    cfg_stop2 = 1'b1;
    wait_frames(f0 + 1);
    check("R12 captured format", mon_bits, ref_frame(8'h6B, 1'b0, 1'b0, 2'd0));
    wait_idle();
    @(negedge clk);
    cfg_len7  = 1'b0;
    cfg_extra = 2'd0;
    cfg_stop2 = 1'b0;

    // R11: pause the baud pulses during the low part of a frame
    mon_en = 1'b0;
    put(8'h00, 1'b0);
    for (int n = 0; n < 50 && txd; n++) @(negedge clk);
    baud_tick = 1'b0;
    lows = 1;
    repeat (20) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    baud_tick = 1'b1;
    @(negedge clk);
    for (int n = 0; n < 200 && txd == 1'b0; n++) begin
      lows++;
      @(negedge clk);
    end
    check("R11 low span with paused pulses", lows, 9 * BIT_CYC + 20);
    wait_idle();
    mon_en = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule